// File: doc/BRIEF.md
# Sleep Interval Timer with Watchdog and Bandgap Duty Control

This block counts one-cycle enables of a slow 32 kHz timebase. At the end of each period it raises a wake interrupt. The period is picked from four fixed lengths by a two-bit select. With the default parameters the lengths are 64, 512, 4096 and 32768 ticks, which is roughly 1.95 ms, 15.6 ms, 125 ms and 1 s.

A watchdog counts these interrupts. If software lets three of them go by without a clear strobe, the watchdog issues a one-cycle system reset pulse. The nominal timeout is therefore three sleep periods.

The block also drives the enable for the reference supply. While the system is awake the enable stays high. While the system sleeps, the enable is pulsed briefly at a rate of its own, so that the supply monitors can still sample. A hold bit can instead keep the enable high for the whole of sleep, which gives faster supervision at the cost of more current.

Top module: `slp_wdt_timer`

## Requirements
- R1: Reset clears the wake interrupt and the watchdog pulse and makes select 00 the active interval. The first period after reset is therefore 2^BASE_LOG2 ticks, whatever the select input holds.
- R2: Select value k (0 to 3) gives a period of 2^(BASE_LOG2 + k*STEP_LOG2) ticks. With the defaults: 00 gives 64, 01 gives 512, 10 gives 4096, 11 gives 32768.
- R3: `wake_irq` is high for exactly one clock. That clock is the one after the clock in which the period's last tick enable is sampled.
- R4: A new select value is taken up only when the current period ends. A period already running keeps its length.
- R5: `wdt_bite` pulses high for one clock. It fires in the clock after the WDT_PERIODS-th wake interrupt counted since reset, since the last clear or since the last bite. The count then starts again from zero.
- R6: A `wdt_clear` strobe sets the watchdog count to zero. If the strobe is sampled in the same clock in which the watchdog sees an interrupt, the clear wins. A clear never changes the interval counter.
- R7: While `sleep_mode` is low, `bg_power_en` is high.
- R8: While sleeping with `bg_hold` low, `bg_power_en` is high for exactly BG_PULSE_CYC clocks. The pulse starts in the clock after every BG_PERIOD_TICKS-th tick enable counted from reset, whatever interval is selected. At all other times the enable is low.
- R9: While sleeping with `bg_hold` high, `bg_power_en` stays high. Once `bg_hold` drops, the duty pulsing of R8 applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick32k_en | input | 1 | One-cycle enable per 32 kHz timebase tick |
| intv_sel | input | 2 | Sleep interval select |
| wdt_clear | input | 1 | Watchdog clear strobe |
| sleep_mode | input | 1 | System is asleep |
| bg_hold | input | 1 | Keep the reference supply on during sleep |
| wake_irq | output | 1 | One-cycle wake interrupt at each period end |
| wdt_bite | output | 1 | One-cycle watchdog reset pulse |
| bg_power_en | output | 1 | Reference supply power enable |

## Verification
The bench builds the block with BASE_LOG2=2 and STEP_LOG2=1, so the four periods are 4, 8, 16 and 32 ticks. WDT_PERIODS is 3, BG_PERIOD_TICKS is 5 and BG_PULSE_CYC is 3. With these values every select value, repeated watchdog expiry and a clear that collides with an interrupt are all reached within a few hundred ticks. Because the duty period of 5 shares no factor with any interval length, the bench can show that bandgap pulsing does not follow the sleep interval.

// File: rtl/slpwd_pkg.sv
package slpwd_pkg;
   localparam int NUM_INTV = 4;
   localparam int SEL_W    = 2;
   typedef logic [SEL_W-1:0] intv_sel_t;

   // log2 of the period length for select value k
   function automatic int intv_log2(input int base_log2, input int step_log2, input int k);
      return base_log2 + k * step_log2;
   endfunction
endpackage

// File: rtl/slpwd_interval.sv
module slpwd_interval #(
   parameter int BASE_LOG2 = 6,
   parameter int STEP_LOG2 = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  slpwd_pkg::intv_sel_t sel_in,
   output logic                 wrap_o
);
   localparam int CNT_W = slpwd_pkg::intv_log2(BASE_LOG2, STEP_LOG2, slpwd_pkg::NUM_INTV - 1);

   logic [CNT_W-1:0]     cnt_q;
   slpwd_pkg::intv_sel_t act_q;
   logic [CNT_W-1:0]     last_v [slpwd_pkg::NUM_INTV];
   logic                 at_last;

   for (genvar k = 0; k < slpwd_pkg::NUM_INTV; k++) begin : g_last
      localparam int LG = slpwd_pkg::intv_log2(BASE_LOG2, STEP_LOG2, k);
      assign last_v[k] = CNT_W'((64'd1 << LG) - 64'd1);
   end

   assign at_last = (cnt_q == last_v[act_q]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         act_q  <= '0;
         wrap_o <= 1'b0;
      end else begin
         wrap_o <= 1'b0;
         if (tick_en) begin
            if (at_last) begin
               cnt_q  <= '0;
               act_q  <= sel_in;
               wrap_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/slpwd_watchdog.sv
module slpwd_watchdog #(
   parameter int WDT_PERIODS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap_i,
   input  logic clear_i,
   output logic bite_o
);
   localparam int WCNT_W = $clog2(WDT_PERIODS + 1);
   localparam logic [WCNT_W-1:0] LAST_SEEN = WCNT_W'(WDT_PERIODS - 1);

   logic [WCNT_W-1:0] seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= '0;
         bite_o <= 1'b0;
      end else begin
         bite_o <= 1'b0;
         if (clear_i) begin
            seen_q <= '0;
         end else if (wrap_i) begin
            if (seen_q == LAST_SEEN) begin
               seen_q <= '0;
               bite_o <= 1'b1;
            end else begin
               seen_q <= seen_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/slpwd_bgduty.sv
module slpwd_bgduty #(
   parameter int BG_PERIOD_TICKS = 32,
   parameter int BG_PULSE_CYC    = 1440
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic sleep_i,
   input  logic hold_i,
   output logic bg_en_o
);
   localparam int PW = $clog2(BG_PULSE_CYC + 1);

   logic          strobe;
   logic [PW-1:0] pcnt_q;

   if (BG_PERIOD_TICKS == 1) begin : g_every
      assign strobe = tick_en;
   end else begin : g_div
      localparam int DW = $clog2(BG_PERIOD_TICKS);
      localparam logic [DW-1:0] DLAST = DW'(BG_PERIOD_TICKS - 1);
      logic [DW-1:0] dcnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dcnt_q <= '0;
         end else if (tick_en) begin
            dcnt_q <= (dcnt_q == DLAST) ? '0 : dcnt_q + 1'b1;
         end
      end
      assign strobe = tick_en && (dcnt_q == DLAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt_q <= '0;
      end else if (strobe) begin
         pcnt_q <= PW'(BG_PULSE_CYC);
      end else if (pcnt_q != '0) begin
         pcnt_q <= pcnt_q - 1'b1;
      end
   end

   assign bg_en_o = !sleep_i || hold_i || (pcnt_q != '0);
endmodule

// File: rtl/slp_wdt_timer.sv
module slp_wdt_timer #(
   parameter int BASE_LOG2       = 6,
   parameter int STEP_LOG2       = 3,
   parameter int WDT_PERIODS     = 3,
   parameter int BG_PERIOD_TICKS = 32,
   parameter int BG_PULSE_CYC    = 1440
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick32k_en,
   input  logic [1:0] intv_sel,
   input  logic       wdt_clear,
   input  logic       sleep_mode,
   input  logic       bg_hold,
   output logic       wake_irq,
   output logic       wdt_bite,
   output logic       bg_power_en
);
   localparam int TOP_LOG2 = slpwd_pkg::intv_log2(BASE_LOG2, STEP_LOG2, slpwd_pkg::NUM_INTV - 1);

   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("BASE_LOG2 must be at least 1");
   end
   if (STEP_LOG2 < 1) begin : g_bad_step
      $error("STEP_LOG2 must be at least 1");
   end
   if (TOP_LOG2 > 31) begin : g_bad_top
      $error("longest interval exceeds 31 counter bits");
   end
   if (WDT_PERIODS < 1) begin : g_bad_wdt
      $error("WDT_PERIODS must be at least 1");
   end
   if (BG_PERIOD_TICKS < 1 || BG_PULSE_CYC < 1) begin : g_bad_bg
      $error("bandgap period and pulse must be at least 1");
   end

   logic wrap;

   slpwd_interval #(
      .BASE_LOG2 (BASE_LOG2),
      .STEP_LOG2 (STEP_LOG2)
   ) u_intv (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick32k_en),
      .sel_in  (intv_sel),
      .wrap_o  (wrap)
   );

   slpwd_watchdog #(
      .WDT_PERIODS (WDT_PERIODS)
   ) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap_i  (wrap),
      .clear_i (wdt_clear),
      .bite_o  (wdt_bite)
   );

   slpwd_bgduty #(
      .BG_PERIOD_TICKS (BG_PERIOD_TICKS),
      .BG_PULSE_CYC    (BG_PULSE_CYC)
   ) u_bg (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick32k_en),
      .sleep_i (sleep_mode),
      .hold_i  (bg_hold),
      .bg_en_o (bg_power_en)
   );

   assign wake_irq = wrap;
endmodule

// File: rtl/slpwd_checker.sv
module slpwd_checker (
   input logic clk,
   input logic rst_n,
   input logic tick32k_en,
   input logic wdt_clear,
   input logic sleep_mode,
   input logic bg_hold,
   input logic wake_irq,
   input logic wdt_bite,
   input logic bg_power_en
);
   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |=> !wake_irq); // R3
   AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> $past(tick32k_en)); // R3
   AST_BITE_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_bite |-> $past(wake_irq)); // R5
   AST_BITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_bite |=> !wdt_bite); // R5
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_bite |-> !$past(wdt_clear)); // R6
   AST_BG_PULSE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_mode && !bg_hold && $stable(sleep_mode) && $stable(bg_hold) && $rose(bg_power_en))
         |-> $past(tick32k_en)); // R8
endmodule

bind slp_wdt_timer slpwd_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick32k_en  (tick32k_en),
   .wdt_clear   (wdt_clear),
   .sleep_mode  (sleep_mode),
   .bg_hold     (bg_hold),
   .wake_irq    (wake_irq),
   .wdt_bite    (wdt_bite),
   .bg_power_en (bg_power_en)
);

// File: tb/sim_slp_wdt_timer.sv
module sim_slp_wdt_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick32k_en = 1'b0;
   logic [1:0] intv_sel = 2'b00;
   logic       wdt_clear = 1'b0;
   logic       sleep_mode = 1'b0;
   logic       bg_hold = 1'b0;
   logic       wake_irq, wdt_bite, bg_power_en;

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;
   int bite_cnt = 0;
   int bg_low_cnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   slp_wdt_timer #(
      .BASE_LOG2(2), .STEP_LOG2(1), .WDT_PERIODS(3),
      .BG_PERIOD_TICKS(5), .BG_PULSE_CYC(3)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .tick32k_en(tick32k_en), .intv_sel(intv_sel),
      .wdt_clear(wdt_clear), .sleep_mode(sleep_mode), .bg_hold(bg_hold),
      .wake_irq(wake_irq), .wdt_bite(wdt_bite), .bg_power_en(bg_power_en)
   );

   always @(negedge clk) begin
      if (wake_irq) irq_cnt++;
      if (wdt_bite) bite_cnt++;
      if (!bg_power_en) bg_low_cnt++;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick32k_en = 1'b0; wdt_clear = 1'b0;
      sleep_mode = 1'b0; bg_hold = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick32k_en = 1'b1;
         @(negedge clk); tick32k_en = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic pulse_clear();
      @(negedge clk); wdt_clear = 1'b1;
      @(negedge clk); wdt_clear = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      int b;
      intv_sel = 2'b10;
      do_reset();
      chk("R1 wake_irq after reset", int'(wake_irq), 0);
      chk("R1 wdt_bite after reset", int'(wdt_bite), 0);
      chk("R7 bg_power_en awake after reset", int'(bg_power_en), 1);
      b = irq_cnt;
      ticks(3);
      chk("R1 no irq before 4th tick", irq_cnt - b, 0);
      ticks(1);
      chk("R1 first period uses select 00", irq_cnt - b, 1);
      chk("R3 irq is a single cycle", int'(wake_irq), 0);
      intv_sel = 2'b00;
   endtask

   task automatic t_intervals();
      int b;
      intv_sel = 2'b00;
      do_reset();
      b = irq_cnt;
      ticks(2);
      intv_sel = 2'b11;
      ticks(1);
      chk("R4 running period keeps old length", irq_cnt - b, 0);
      ticks(1);
      chk("R4 old period ends at 4 ticks", irq_cnt - b, 1);
      ticks(31);
      chk("R2 select 11 not done at 31", irq_cnt - b, 1);
      intv_sel = 2'b01;
      ticks(1);
      chk("R2 select 11 gives 32 ticks", irq_cnt - b, 2);
      ticks(7);
      chk("R2 select 01 not done at 7", irq_cnt - b, 2);
      intv_sel = 2'b10;
      ticks(1);
      chk("R2 select 01 gives 8 ticks", irq_cnt - b, 3);
      ticks(15);
      chk("R2 select 10 not done at 15", irq_cnt - b, 3);
      ticks(1);
      chk("R2 select 10 gives 16 ticks", irq_cnt - b, 4);
      intv_sel = 2'b00;
   endtask

   task automatic t_watchdog();
      int b;
      intv_sel = 2'b00;
      do_reset();
      b = bite_cnt;
      ticks(8);
      chk("R5 no bite after two periods", bite_cnt - b, 0);
      ticks(4);
      chk("R5 bite after third period", bite_cnt - b, 1);
      chk("R5 bite is a single cycle", int'(wdt_bite), 0);
      ticks(8);
      chk("R5 count restarts after bite", bite_cnt - b, 1);
      ticks(4);
      chk("R5 second bite after three more", bite_cnt - b, 2);
   endtask

   task automatic t_clear();
      int b, bi;
      intv_sel = 2'b00;
      do_reset();
      b = bite_cnt; bi = irq_cnt;
      ticks(2);
      pulse_clear();
      ticks(1);
      chk("R6 clear leaves interval counter", irq_cnt - bi, 0);
      ticks(1);
      chk("R6 interval ends on schedule after clear", irq_cnt - bi, 1);
      ticks(4);
      pulse_clear();
      ticks(8);
      chk("R6 clear restarts watchdog count", bite_cnt - b, 0);
      ticks(4);
      chk("R6 bite three periods after clear", bite_cnt - b, 1);
      // clear sampled together with the interrupt
      ticks(11);
      @(negedge clk); tick32k_en = 1'b1;
      @(negedge clk); tick32k_en = 1'b0; wdt_clear = 1'b1;
      @(negedge clk); wdt_clear = 1'b0;
      repeat (2) @(negedge clk);
      chk("R6 colliding clear wins", bite_cnt - b, 1);
      ticks(8);
      chk("R6 count zero after colliding clear", bite_cnt - b, 1);
      ticks(4);
      chk("R6 bite after colliding clear", bite_cnt - b, 2);
   endtask

   task automatic t_bandgap_duty();
      int hi;
      int l;
      intv_sel = 2'b11;
      do_reset();
      l = bg_low_cnt;
      ticks(4);
      chk("R7 awake keeps enable high", bg_low_cnt - l, 0);
      sleep_mode = 1'b1;
      @(negedge clk);
      chk("R8 enable low in sleep between pulses", int'(bg_power_en), 0);
      tick32k_en = 1'b1;
      @(negedge clk); tick32k_en = 1'b0;
      hi = 0;
      for (int i = 0; i < 8; i++) begin
         if (i > 0) @(negedge clk);
         if (bg_power_en) hi++;
      end
      chk("R8 pulse width after 5th tick", hi, 3);
      ticks(4);
      chk("R8 no pulse before next 5 ticks", int'(bg_power_en), 0);
      @(negedge clk); tick32k_en = 1'b1;
      @(negedge clk); tick32k_en = 1'b0;
      chk("R8 pulse repeats every 5 ticks", int'(bg_power_en), 1);
      sleep_mode = 1'b0;
      intv_sel = 2'b00;
   endtask

   task automatic t_hold();
      int l;
      do_reset();
      sleep_mode = 1'b1; bg_hold = 1'b1;
      @(negedge clk);
      l = bg_low_cnt;
      ticks(12);
      chk("R9 hold keeps enable high in sleep", bg_low_cnt - l, 0);
      bg_hold = 1'b0;
      @(negedge clk);
      chk("R9 dropping hold restores duty", int'(bg_power_en), 0);
      sleep_mode = 1'b0;
      @(negedge clk);
      chk("R7 wake raises enable", int'(bg_power_en), 1);
   endtask

   initial begin
      t_reset_state();
      t_intervals();
      t_watchdog();
      t_clear();
      t_bandgap_duty();
      t_hold();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule